// File: doc/BRIEF.md
# Transmit De-emphasis Level Controller

This block sits in front of a serial line driver and decides, one bit at a time, how hard the driver should push. Each accepted bit produces a drive word made of a polarity and a 5-bit amplitude code. When a bit differs from the bit accepted before it, it is driven at full swing. When a bit repeats the value before it, it is driven at a reduced amplitude. This keeps charge from building up on a long AC-coupled cable, and the next change of value then stands out at full swing again.

How much a repeated bit is reduced is set by a 3-bit attenuation select, so the reduction can be matched to the cable. A boost select raises full scale from the normal level to the double level, for long runs of cable. Reduced levels scale with whichever full scale is in force.

Input bits arrive as a stream qualified by `bit_vld`. The block accepts a bit in every cycle where `bit_vld` is high. It applies no back-pressure, so there is no ready signal and the source never stalls. The output word is qualified by `drv_vld`, which pulses for one cycle for each accepted bit. Between pulses the output word holds its value. The analog driver that consumes the word is outside this block.

Top module: `deemph_drive`

## Requirements
- R1: After reset, `drv_vld` is 0, `drv_pol` is 0 and `drv_amp` is 0.
- R2: An accepted bit whose value differs from the previously accepted bit is driven at full scale: `drv_amp` = 16 when `boost` = 0.
- R3: An accepted bit equal to the previously accepted bit is driven at the reduced level floor(F*(8-A)/8). F is the full scale in force and A is `atten_sel` (0..7). With F = 16 this gives 16 - 2*A.
- R4: With `atten_sel` = 0, repeated bits are driven at full scale, so no reduction takes place.
- R5: With `boost` = 1, full scale F is 31. A transition gives 31, and a repeat gives floor(31*(8-A)/8), for example 27 for A = 1 and 3 for A = 7.
- R6: In a cycle with `bit_vld` = 0, `drv_pol` and `drv_amp` keep their values and the bit history does not change. The first bit accepted after a gap is compared with the last bit accepted before the gap.
- R7: The bit history resets to 0. A first bit of 1 after reset is therefore a transition (full scale), and a first bit of 0 is a repeat (reduced level).
- R8: `drv_vld` is 1 in the cycle after each cycle with `bit_vld` = 1, and 0 in the cycle after each cycle with `bit_vld` = 0.
- R9: `drv_pol` equals the value of the accepted bit, with 1 meaning positive polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Input bit valid; the bit is accepted in every cycle where this is high |
| bit_val | input | 1 | Serial bit value |
| atten_sel | input | 3 | Reduction step for repeated bits, in eighths of full scale |
| boost | input | 1 | 1 selects double full scale (31); 0 selects normal full scale (16) |
| drv_vld | output | 1 | Pulses for one cycle when a new drive word is available |
| drv_pol | output | 1 | Drive polarity |
| drv_amp | output | 5 | Drive amplitude code |

## Verification
Every result is due exactly one clock edge after the cycle in which its bit is offered. That covers `drv_vld`, `drv_pol` and `drv_amp`. The amplitude is decided from `atten_sel` and `boost` as sampled on that same edge. The bench changes inputs on the falling edge. It compares all three outputs at the next falling edge against a model that tracks the last accepted bit. Idle cycles are checked in the same slot, to confirm that the outputs held and that the history carried across the gap.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
  localparam int AMP_W     = 5;
  localparam int SET_W     = 3;
  localparam int FULL_NORM = 16;
  localparam int FULL_DBL  = 31;
endpackage

// File: rtl/deemph_history.sv
module deemph_history (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic bit_in,
  output logic repeat_o
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= 1'b0;
    else if (take) last_q <= bit_in;
  end

  assign repeat_o = (bit_in == last_q);
endmodule

// File: rtl/deemph_scaler.sv
module deemph_scaler #(
  parameter int AMP_W     = 5,
  parameter int SET_W     = 3,
  parameter int FULL_NORM = 16,
  parameter int FULL_DBL  = 31
) (
  input  logic             repeat_i,
  input  logic [SET_W-1:0] sel_i,
  input  logic             dbl_i,
  output logic [AMP_W-1:0] amp_o
);
  localparam int STEPS  = 1 << SET_W;
  localparam int PROD_W = AMP_W + SET_W + 1;

  logic [AMP_W-1:0]  full;
  logic [SET_W:0]    keep;
  logic [PROD_W-1:0] prod;

  always_comb begin
    full  = dbl_i ? AMP_W'(FULL_DBL) : AMP_W'(FULL_NORM);
    keep  = (SET_W+1)'(STEPS) - {1'b0, sel_i};
    prod  = PROD_W'(full) * PROD_W'(keep);
    amp_o = repeat_i ? AMP_W'(prod >> SET_W) : full;
  end
endmodule

// File: rtl/deemph_outreg.sv
module deemph_outreg #(
  parameter int AMP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             pol_d,
  input  logic [AMP_W-1:0] amp_d,
  output logic             vld_q,
  output logic             pol_q,
  output logic [AMP_W-1:0] amp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pol_q <= 1'b0;
      amp_q <= '0;
    end else begin
      vld_q <= load;
      if (load) begin
        pol_q <= pol_d;
        amp_q <= amp_d;
      end
    end
  end
endmodule

// File: rtl/deemph_drive.sv
module deemph_drive
  import deemph_pkg::*;
#(
  parameter int A_W  = AMP_W,
  parameter int S_W  = SET_W,
  parameter int F_NO = FULL_NORM,
  parameter int F_DB = FULL_DBL
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_vld,
  input  logic           bit_val,
  input  logic [S_W-1:0] atten_sel,
  input  logic           boost,
  output logic           drv_vld,
  output logic           drv_pol,
  output logic [A_W-1:0] drv_amp
);
  logic           is_repeat;
  logic [A_W-1:0] amp_next;

  deemph_history u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (bit_vld),
    .bit_in   (bit_val),
    .repeat_o (is_repeat)
  );

  deemph_scaler #(
    .AMP_W(A_W), .SET_W(S_W), .FULL_NORM(F_NO), .FULL_DBL(F_DB)
  ) u_scale (
    .repeat_i (is_repeat),
    .sel_i    (atten_sel),
    .dbl_i    (boost),
    .amp_o    (amp_next)
  );

  deemph_outreg #(.AMP_W(A_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (bit_vld),
    .pol_d (bit_val),
    .amp_d (amp_next),
    .vld_q (drv_vld),
    .pol_q (drv_pol),
    .amp_q (drv_amp)
  );
endmodule

// File: rtl/deemph_drive_chk.sv
module deemph_drive_chk #(
  parameter int A_W  = 5,
  parameter int S_W  = 3,
  parameter int F_NO = 16,
  parameter int F_DB = 31
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_vld,
  input logic           bit_val,
  input logic [S_W-1:0] atten_sel,
  input logic           boost,
  input logic           drv_vld,
  input logic           drv_pol,
  input logic [A_W-1:0] drv_amp
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (bit_vld) seen_q <= bit_val;
  end

  // R8
  assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> drv_vld);
  // R8
  assert_idle_no_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !drv_vld);
  // R6
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> ($stable(drv_pol) && $stable(drv_amp)));
  // R9
  assert_pol_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> (drv_pol == $past(bit_val)));
  // R2 / R5
  assert_edge_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_val != seen_q) |=>
      (drv_amp == ($past(boost) ? A_W'(F_DB) : A_W'(F_NO))));
  // R4
  assert_no_atten_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && atten_sel == '0) |=>
      (drv_amp == ($past(boost) ? A_W'(F_DB) : A_W'(F_NO))));
  // R3
  assert_repeat_not_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_val == seen_q && !boost) |=> (drv_amp <= A_W'(F_NO)));
endmodule

bind deemph_drive deemph_drive_chk #(
  .A_W(A_W), .S_W(S_W), .F_NO(F_NO), .F_DB(F_DB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
  .atten_sel(atten_sel), .boost(boost), .drv_vld(drv_vld),
  .drv_pol(drv_pol), .drv_amp(drv_amp)
);

// File: tb/deemph_drive_tb.sv
`timescale 1ns/1ps
module deemph_drive_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_val = 1'b0;
  logic [2:0] atten_sel = 3'd0;
  logic       boost = 1'b0;
  logic       drv_vld;
  logic       drv_pol;
  logic [4:0] drv_amp;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic       m_prev = 1'b0;
  logic       e_vld = 1'b0;
  logic       e_pol = 1'b0;
  logic [4:0] e_amp = 5'd0;
  string      tag;

  always #10 clk = ~clk;

  deemph_drive u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .atten_sel(atten_sel), .boost(boost), .drv_vld(drv_vld),
    .drv_pol(drv_pol), .drv_amp(drv_amp)
  );

  function automatic int full_of(input logic dbl);
    return dbl ? 31 : 16;
  endfunction

  function automatic int level_of(input logic rep, input int a, input logic dbl);
    if (!rep) return full_of(dbl);
    return (full_of(dbl) * (8 - a)) / 8;
  endfunction

  task automatic check(input string t);
    vectors++;
    if (drv_vld !== e_vld || drv_pol !== e_pol || drv_amp !== e_amp) begin
      errors++;
      $display("FAIL %s: vld/pol/amp got %0b/%0b/%0d expected %0b/%0b/%0d",
               t, drv_vld, drv_pol, drv_amp, e_vld, e_pol, e_amp);
    end
  endtask

  // called at a falling edge; result checked at the next falling edge
  task automatic step(input logic en, input logic b, input int a, input logic dbl);
    bit_vld   = en;
    bit_val   = b;
    atten_sel = 3'(a);
    boost     = dbl;
    if (en) begin
      if (b != m_prev)  tag = dbl ? "R2/R5 R9 R8" : "R2 R9 R8";
      else if (a == 0)  tag = dbl ? "R4/R5 R8" : "R4 R8";
      else              tag = dbl ? "R3/R5 R8" : "R3 R8";
      e_amp  = 5'(level_of(b == m_prev, a, dbl));
      e_pol  = b;
      e_vld  = 1'b1;
      m_prev = b;
    end else begin
      tag   = "R6 R8";
      e_vld = 1'b0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_prev = 1'b0; e_vld = 1'b0; e_pol = 1'b0; e_amp = 5'd0;
    check("R1 reset");
  endtask

  initial begin
    void'($urandom(32'd7351));
    @(negedge clk);
    do_reset();
    // R7: first bit 0 after reset is a repeat
    step(1'b1, 1'b0, 3, 1'b0);
    if (drv_amp !== 5'd10) begin errors++; $display("FAIL R7: amp %0d expected 10", drv_amp); end
    vectors++;
    do_reset();
    // R7: first bit 1 after reset is a transition
    step(1'b1, 1'b1, 3, 1'b0);
    // long run then transition (R3, R2)
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 7, 1'b0);
    step(1'b1, 1'b0, 7, 1'b0);
    // R4: no attenuation
    step(1'b1, 1'b0, 0, 1'b0);
    step(1'b1, 1'b0, 0, 1'b1);
    // R5: double scale corners
    step(1'b1, 1'b1, 1, 1'b1);
    step(1'b1, 1'b1, 1, 1'b1);
    step(1'b1, 1'b1, 7, 1'b1);
    // R6: idle gap with toggling inputs, history kept
    step(1'b0, 1'b0, 2, 1'b0);
    step(1'b0, 1'b0, 5, 1'b1);
    step(1'b1, 1'b1, 2, 1'b0);
    step(1'b0, 1'b0, 4, 1'b0);
    step(1'b1, 1'b0, 4, 1'b0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 4);
      step(r != 0, 1'($urandom), int'($urandom % 8), 1'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule